// File: doc/BRIEF.md
# Register Rename Map and Free List

This block renames one instruction per clock. Each incoming instruction names up to two architectural source registers and at most one architectural destination. The block looks up the current physical register behind each source, takes a fresh physical register from a pool of unused ones for the destination, and points the destination's map entry at it. Alongside the new destination it reports the physical register that the destination was mapped to before. The surrounding pipeline keeps that register and hands it back through the release port once the overwriting instruction has committed, after every older instruction has committed.

Because every write gets a new physical register, false dependences are removed: write-after-read and write-after-write hazards disappear. True read-after-write dependences stay visible, because a later reader picks up the producer's new physical number. The input uses a valid/ready handshake. When the pool is empty and the instruction needs a destination, the block holds ready low and leaves all of its state untouched. Results appear on registered outputs one cycle after the instruction is accepted.

Top module: `reg_rename`

## Requirements
- R1: After reset, architectural register k maps to physical register k for every k below NUM_ARCH.
- R2: After reset, the pool holds physical registers NUM_ARCH up to NUM_PHYS-1 and hands them out in ascending order.
- R3: Source lookups use the map as it stood before this instruction's own destination update. An instruction that reads and writes the same register sees the old physical number on its source.
- R4: For an instruction with a destination, out_prev_phys carries the physical register the destination was mapped to before, and it always differs from out_dst_phys.
- R5: The newly allocated register is written into the map, so later readers of that architectural register receive it.
- R6: An instruction with in_dst_valid low allocates nothing and does not change the map. Its out_dst_valid is 0, and out_dst_phys and out_prev_phys read 0.
- R7: A source with its valid flag low reports physical number 0, and its valid flag is passed through to the output.
- R8: When the pool is empty and in_dst_valid is high, in_ready is low, nothing is accepted, out_valid stays low and the map is unchanged. An instruction without a destination is still accepted while the pool is empty.
- R9: A register returned through free_valid/free_phys joins the tail of the pool and is handed out after every register already waiting in it.
- R10: An allocation and a release in the same cycle both take effect.
- R11: out_valid pulses high for exactly the one cycle after each accepted instruction, and it is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered for renaming |
| in_ready | output | 1 | Instruction will be accepted this cycle |
| in_src1_valid | input | 1 | First source names a register |
| in_src1_arch | input | $clog2(NUM_ARCH) | First source architectural number |
| in_src2_valid | input | 1 | Second source names a register |
| in_src2_arch | input | $clog2(NUM_ARCH) | Second source architectural number |
| in_dst_valid | input | 1 | Instruction writes a register |
| in_dst_arch | input | $clog2(NUM_ARCH) | Destination architectural number |
| out_valid | output | 1 | Renamed result present |
| out_src1_valid | output | 1 | First source flag, passed through |
| out_src1_phys | output | $clog2(NUM_PHYS) | First source physical number |
| out_src2_valid | output | 1 | Second source flag, passed through |
| out_src2_phys | output | $clog2(NUM_PHYS) | Second source physical number |
| out_dst_valid | output | 1 | Destination flag, passed through |
| out_dst_phys | output | $clog2(NUM_PHYS) | Newly allocated physical destination |
| out_prev_phys | output | $clog2(NUM_PHYS) | Former mapping of the destination, to release later |
| free_valid | input | 1 | A committed instruction releases a register |
| free_phys | input | $clog2(NUM_PHYS) | Physical register being released |

## Verification
Allocation for a renamed destination and the return of a released register can happen in the same clock edge. The bench provokes this by driving free_valid together with an accepted instruction that has a destination, at a point where one register is left in the pool. It then judges the outcome by the order of later grants: the renamed instruction must get the last waiting register, and the released register must come out next. Further releases followed by renames check the tail ordering of the pool. An empty-pool stall that is ended by a release checks that the map survived the stall.

// File: rtl/rename_pkg.sv
`timescale 1ns/1ps
package rename_pkg;
    localparam int DEF_ARCH_REGS = 8;
    localparam int DEF_PHYS_REGS = 16;
endpackage

// File: rtl/rn_map_table.sv
`timescale 1ns/1ps
module rn_map_table #(
    parameter int NUM_ARCH = rename_pkg::DEF_ARCH_REGS,
    parameter int NUM_PHYS = rename_pkg::DEF_PHYS_REGS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(NUM_ARCH)-1:0] rd_a_i,
    output logic [$clog2(NUM_PHYS)-1:0] rd_a_o,
    input  logic [$clog2(NUM_ARCH)-1:0] rd_b_i,
    output logic [$clog2(NUM_PHYS)-1:0] rd_b_o,
    input  logic [$clog2(NUM_ARCH)-1:0] rd_c_i,
    output logic [$clog2(NUM_PHYS)-1:0] rd_c_o,
    input  logic                        wr_en_i,
    input  logic [$clog2(NUM_ARCH)-1:0] wr_arch_i,
    input  logic [$clog2(NUM_PHYS)-1:0] wr_phys_i
);
    localparam int PW = $clog2(NUM_PHYS);

    typedef logic [NUM_ARCH-1:0][PW-1:0] map_t;
    map_t map_d, map_q;

    // reads see the registered map only, so they precede this cycle's write
    assign rd_a_o = map_q[rd_a_i];
    assign rd_b_o = map_q[rd_b_i];
    assign rd_c_o = map_q[rd_c_i];

    always_comb begin
        map_d = map_q;
        if (wr_en_i) map_d[wr_arch_i] = wr_phys_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_ARCH; k++) map_q[k] <= PW'(k);
        end else begin
            map_q <= map_d;
        end
    end

    // R5: a write is visible in the entry on the following cycle
    a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> map_q[$past(wr_arch_i)] == $past(wr_phys_i));
    // R8: no write request leaves every entry alone
    a_r8_map_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(map_q));
endmodule

// File: rtl/rn_free_list.sv
`timescale 1ns/1ps
module rn_free_list #(
    parameter int NUM_ARCH = rename_pkg::DEF_ARCH_REGS,
    parameter int NUM_PHYS = rename_pkg::DEF_PHYS_REGS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        alloc_i,
    output logic [$clog2(NUM_PHYS)-1:0] alloc_phys_o,
    output logic                        empty_o,
    input  logic                        rel_i,
    input  logic [$clog2(NUM_PHYS)-1:0] rel_phys_i
);
    localparam int PW    = $clog2(NUM_PHYS);
    localparam int DEPTH = NUM_PHYS - NUM_ARCH;
    localparam int IW    = $clog2(DEPTH);
    localparam int CW    = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][PW-1:0] slot;
        logic [IW-1:0]            head;
        logic [IW-1:0]            tail;
        logic [CW-1:0]            count;
    } fl_t;

    fl_t st_d, st_q;

    function automatic logic [IW-1:0] step(input logic [IW-1:0] p);
        return (p == IW'(DEPTH - 1)) ? '0 : p + IW'(1);
    endfunction

    assign alloc_phys_o = st_q.slot[st_q.head];
    assign empty_o      = (st_q.count == '0);

    always_comb begin
        st_d = st_q;
        if (alloc_i) st_d.head = step(st_q.head);
        if (rel_i) begin
            st_d.slot[st_q.tail] = rel_phys_i;
            st_d.tail            = step(st_q.tail);
        end
        st_d.count = st_q.count + CW'(rel_i) - CW'(alloc_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) st_q.slot[k] <= PW'(NUM_ARCH + k);
            st_q.head  <= '0;
            st_q.tail  <= '0;
            st_q.count <= CW'(DEPTH);
        end else begin
            st_q <= st_d;
        end
    end

    // R8: never grant from an empty pool
    a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> st_q.count != '0);
    // R9: a release never lands in a full pool
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        rel_i |-> st_q.count != CW'(DEPTH));
    // R10: grant plus release in one cycle keeps the occupancy
    a_r10_count_balance: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && rel_i) |=> $stable(st_q.count));
    // R2: a lone grant shrinks the pool by one
    a_r2_count_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && !rel_i) |=> st_q.count == $past(st_q.count) - CW'(1));
endmodule

// File: rtl/reg_rename.sv
`timescale 1ns/1ps
module reg_rename #(
    parameter int NUM_ARCH = rename_pkg::DEF_ARCH_REGS,
    parameter int NUM_PHYS = rename_pkg::DEF_PHYS_REGS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic                        in_src1_valid,
    input  logic [$clog2(NUM_ARCH)-1:0] in_src1_arch,
    input  logic                        in_src2_valid,
    input  logic [$clog2(NUM_ARCH)-1:0] in_src2_arch,
    input  logic                        in_dst_valid,
    input  logic [$clog2(NUM_ARCH)-1:0] in_dst_arch,
    output logic                        out_valid,
    output logic                        out_src1_valid,
    output logic [$clog2(NUM_PHYS)-1:0] out_src1_phys,
    output logic                        out_src2_valid,
    output logic [$clog2(NUM_PHYS)-1:0] out_src2_phys,
    output logic                        out_dst_valid,
    output logic [$clog2(NUM_PHYS)-1:0] out_dst_phys,
    output logic [$clog2(NUM_PHYS)-1:0] out_prev_phys,
    input  logic                        free_valid,
    input  logic [$clog2(NUM_PHYS)-1:0] free_phys
);
    localparam int PW = $clog2(NUM_PHYS);

    typedef struct packed {
        logic          valid;
        logic          s1v;
        logic [PW-1:0] s1p;
        logic          s2v;
        logic [PW-1:0] s2p;
        logic          dv;
        logic [PW-1:0] dp;
        logic [PW-1:0] pp;
    } res_t;

    res_t res_d, res_q;

    logic [PW-1:0] map_s1, map_s2, map_dst, grant_phys;
    logic          pool_empty, accept, alloc;

    assign in_ready = !(in_dst_valid && pool_empty);
    assign accept   = in_valid && in_ready;
    assign alloc    = accept && in_dst_valid;

    rn_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_i    (in_src1_arch),
        .rd_a_o    (map_s1),
        .rd_b_i    (in_src2_arch),
        .rd_b_o    (map_s2),
        .rd_c_i    (in_dst_arch),
        .rd_c_o    (map_dst),
        .wr_en_i   (alloc),
        .wr_arch_i (in_dst_arch),
        .wr_phys_i (grant_phys)
    );

    rn_free_list #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_pool (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_i      (alloc),
        .alloc_phys_o (grant_phys),
        .empty_o      (pool_empty),
        .rel_i        (free_valid),
        .rel_phys_i   (free_phys)
    );

    always_comb begin
        res_d       = '0;
        res_d.valid = accept;
        res_d.s1v   = in_src1_valid;
        res_d.s2v   = in_src2_valid;
        res_d.dv    = in_dst_valid;
        if (in_src1_valid) res_d.s1p = map_s1;
        if (in_src2_valid) res_d.s2p = map_s2;
        if (in_dst_valid) begin
            res_d.dp = grant_phys;
            res_d.pp = map_dst;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid      = res_q.valid;
    assign out_src1_valid = res_q.s1v;
    assign out_src1_phys  = res_q.s1p;
    assign out_src2_valid = res_q.s2v;
    assign out_src2_phys  = res_q.s2p;
    assign out_dst_valid  = res_q.dv;
    assign out_dst_phys   = res_q.dp;
    assign out_prev_phys  = res_q.pp;

    // R11: every accepted instruction yields a result next cycle
    a_r11_accept_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
    // R8: a stalled instruction produces nothing
    a_r8_stall_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |=> !out_valid);
    // R4: the fresh destination never equals the displaced one
    a_r4_fresh_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_dst_valid) |-> out_dst_phys != out_prev_phys);
endmodule

// File: tb/reg_rename_test.sv
`timescale 1ns/1ps
module reg_rename_test;
    localparam int NA = 8;
    localparam int NP = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic       in_src1_valid = 1'b0;
    logic [2:0] in_src1_arch = '0;
    logic       in_src2_valid = 1'b0;
    logic [2:0] in_src2_arch = '0;
    logic       in_dst_valid = 1'b0;
    logic [2:0] in_dst_arch = '0;
    logic       out_valid, out_src1_valid, out_src2_valid, out_dst_valid;
    logic [3:0] out_src1_phys, out_src2_phys, out_dst_phys, out_prev_phys;
    logic       free_valid = 1'b0;
    logic [3:0] free_phys = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    reg_rename #(.NUM_ARCH(NA), .NUM_PHYS(NP)) uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_src1_valid(in_src1_valid), .in_src1_arch(in_src1_arch),
        .in_src2_valid(in_src2_valid), .in_src2_arch(in_src2_arch),
        .in_dst_valid(in_dst_valid), .in_dst_arch(in_dst_arch),
        .out_valid(out_valid),
        .out_src1_valid(out_src1_valid), .out_src1_phys(out_src1_phys),
        .out_src2_valid(out_src2_valid), .out_src2_phys(out_src2_phys),
        .out_dst_valid(out_dst_valid), .out_dst_phys(out_dst_phys),
        .out_prev_phys(out_prev_phys),
        .free_valid(free_valid), .free_phys(free_phys)
    );

    // {src1, src2, dst (3 bits each), exp src1, exp src2, exp dst, exp prev (4 bits each)}
    localparam int NVEC = 6;
    localparam logic [24:0] VEC [NVEC] = '{
        {3'd2, 3'd3, 3'd1, 4'd2,  4'd3,  4'd8,  4'd1},
        {3'd2, 3'd1, 3'd3, 4'd2,  4'd8,  4'd9,  4'd3},
        {3'd2, 3'd3, 3'd2, 4'd2,  4'd9,  4'd10, 4'd2},
        {3'd1, 3'd1, 3'd1, 4'd8,  4'd8,  4'd11, 4'd8},
        {3'd4, 3'd5, 3'd6, 4'd4,  4'd5,  4'd12, 4'd6},
        {3'd6, 3'd2, 3'd0, 4'd12, 4'd10, 4'd13, 4'd0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic rn(input logic s1v, input int s1, input logic s2v, input int s2,
                      input logic dv, input int d,
                      input int e1, input int e2, input int ed, input int ep,
                      input logic rv, input int rp, input string tag);
        @(negedge clk);
        in_valid      = 1'b1;
        in_src1_valid = s1v; in_src1_arch = 3'(s1);
        in_src2_valid = s2v; in_src2_arch = 3'(s2);
        in_dst_valid  = dv;  in_dst_arch  = 3'(d);
        free_valid    = rv;  free_phys    = 4'(rp);
        #1;
        chk({tag, " ready"}, int'(in_ready), 1);
        @(negedge clk);
        in_valid   = 1'b0;
        free_valid = 1'b0;
        chk({tag, " out_valid"}, int'(out_valid), 1);
        chk({tag, " src1 valid"}, int'(out_src1_valid), int'(s1v));
        chk({tag, " src1"}, int'(out_src1_phys), e1);
        chk({tag, " src2 valid"}, int'(out_src2_valid), int'(s2v));
        chk({tag, " src2"}, int'(out_src2_phys), e2);
        chk({tag, " dst valid"}, int'(out_dst_valid), int'(dv));
        chk({tag, " dst"}, int'(out_dst_phys), ed);
        chk({tag, " prev"}, int'(out_prev_phys), ep);
        @(negedge clk);
        chk({tag, " single pulse R11"}, int'(out_valid), 0);
    endtask

    task automatic release_reg(input int p);
        @(negedge clk);
        free_valid = 1'b1; free_phys = 4'(p);
        @(negedge clk);
        free_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: no result right after reset
        chk("R11 reset out_valid", int'(out_valid), 0);
        chk("R1 reset ready", int'(in_ready), 1);

        // Table: R1 identity, R2 ascending grants, R3/R4/R5 chains
        for (int i = 0; i < NVEC; i++) begin
            rn(1'b1, int'(VEC[i][24:22]), 1'b1, int'(VEC[i][21:19]), 1'b1, int'(VEC[i][18:16]),
               int'(VEC[i][15:12]), int'(VEC[i][11:8]), int'(VEC[i][7:4]), int'(VEC[i][3:0]),
               1'b0, 0, $sformatf("R1/R2/R3/R4/R5 vec%0d", i));
        end
        // map now r0=13 r1=11 r2=10 r3=9 r4=4 r5=5 r6=12 r7=7; pool 14,15

        // R6: no destination, nothing consumed
        rn(1'b1, 3, 1'b1, 7, 1'b0, 2, 9, 7, 0, 0, 1'b0, 0, "R6 no dest");
        // R7: second source unused; grant shows R6 consumed nothing
        rn(1'b1, 0, 1'b0, 6, 1'b1, 4, 13, 0, 14, 4, 1'b0, 0, "R7 imm src");
        // R10: last grant and a release of p1 in the same cycle
        rn(1'b1, 5, 1'b1, 5, 1'b1, 5, 5, 5, 15, 5, 1'b1, 1, "R10 same cycle");
        release_reg(3);
        // R9: pool order is p1 then p3
        rn(1'b1, 7, 1'b0, 0, 1'b1, 7, 7, 0, 1, 7, 1'b0, 0, "R9 order a R10");
        rn(1'b1, 0, 1'b0, 0, 1'b1, 0, 13, 0, 3, 13, 1'b0, 0, "R9 order b");
        // pool empty: R8 no-dest instruction still accepted
        rn(1'b1, 1, 1'b0, 0, 1'b0, 0, 11, 0, 0, 0, 1'b0, 0, "R8 empty nodest");

        // R8: stall with a destination
        @(negedge clk);
        in_valid = 1'b1;
        in_src1_valid = 1'b1; in_src1_arch = 3'd2;
        in_src2_valid = 1'b0; in_src2_arch = 3'd0;
        in_dst_valid  = 1'b1; in_dst_arch  = 3'd2;
        #1;
        chk("R8 stall ready", int'(in_ready), 0);
        @(negedge clk);
        chk("R8 stall no out", int'(out_valid), 0);
        free_valid = 1'b1; free_phys = 4'd2;
        @(negedge clk);
        free_valid = 1'b0;
        chk("R8 stall no out 2", int'(out_valid), 0);
        #1;
        chk("R8 resume ready", int'(in_ready), 1);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 resume out_valid", int'(out_valid), 1);
        chk("R8 map kept src1", int'(out_src1_phys), 10);
        chk("R8 resume dst", int'(out_dst_phys), 2);
        chk("R8 map kept prev", int'(out_prev_phys), 10);

        // R1/R2 again after a mid-run reset
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R11 reset again", int'(out_valid), 0);
        rn(1'b1, 5, 1'b1, 0, 1'b1, 5, 5, 0, 8, 5, 1'b0, 0, "R1/R2 after reset");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule